// File: doc/BRIEF.md
# Test-port instruction register with decoder and serial-output selection

This block holds the instruction of a boundary-scan test port. New instruction bits are shifted serially from the test data input into a scan layer. They are copied into a separate held layer only when the controller strobes an update. The decoder therefore only ever sees complete instructions. The decoder turns the held instruction into a test-mode flag and a select code. That code chooses which data register drives the serial test output: the built-in one-bit bypass stage, the external boundary chain or the external identification register.

The controller state machine is not part of this block. It supplies the capture, shift and update strobes as levels that are valid for one test-clock cycle, plus an indication that it sits in its reset state. Scan-layer and bypass flops move on the rising edge. The held layer and the serial output move on the falling edge. A synchronous active-high reset forces the same state as the controller reset indication.

Top module: `scan_ir_unit`

## Requirements
- R1: After reset, the held instruction is the identification code (0010), so `dr_sel_o` is 2'b10, `mode_o` is 0 and `tdo_o` is 0. With `HAS_ID`=0 the reset instruction is bypass (1111), which gives `dr_sel_o` 2'b00.
- R2: A cycle with `ir_capture_i` high loads the scan layer with 0001, LSB first out. The first four shifted-out bits are therefore 1,0,0,0.
- R3: In each cycle with `ir_shift_i` high, `tdo_o` shows the scan-layer LSB from the falling edge of that cycle. At the rising edge that closes the cycle, `tdi_i` enters the MSB. A bit shifted in reappears on `tdo_o` four shift cycles later.
- R4: Capturing or shifting the scan layer leaves `mode_o` and `dr_sel_o` unchanged.
- R5: A cycle with `ir_update_i` high copies the scan layer into the held layer at that cycle's falling edge. The new decode is visible in the same cycle.
- R6: Decoding is as follows. 0000 gives `mode_o`=1 and `dr_sel_o`=01 (boundary). 0001 gives mode 0 and select 01. 0010 gives select 10 (identification), or 00 when `HAS_ID`=0. Every other code, including 1111, gives mode 0 and select 00 (bypass).
- R7: The bypass stage loads 0 in a cycle with `dr_capture_i` high. With bypass selected and `dr_shift_i` high, `tdo_o` equals `tdi_i` from the previous shift cycle, and 0 in the first shift cycle.
- R8: When `dr_shift_i` is high (and `ir_shift_i` is low), `tdo_o` takes the selected register's serial output at the falling edge. When neither shift strobe is high, `tdo_o` is 0.
- R9: `tlr_i` high in a cycle reloads the reset instruction at that cycle's falling edge, whatever was held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi_i | input | 1 | Serial test data in |
| tlr_i | input | 1 | Controller is in its reset state |
| ir_capture_i | input | 1 | Capture strobe for the instruction scan layer |
| ir_shift_i | input | 1 | Shift strobe for the instruction scan layer |
| ir_update_i | input | 1 | Update strobe (scan layer to held layer) |
| dr_capture_i | input | 1 | Data-register capture strobe |
| dr_shift_i | input | 1 | Data-register shift strobe |
| bsr_so_i | input | 1 | Serial output of the boundary chain |
| idr_so_i | input | 1 | Serial output of the identification register |
| mode_o | output | 1 | Test mode: boundary cells drive the pins |
| dr_sel_o | output | 2 | Selected data register: 00 bypass, 01 boundary, 10 identification |
| tdo_o | output | 1 | Serial test data out |

## Verification
The bench drives the strobes just after a rising edge and samples two nanoseconds after the following falling edge. At that point an update, a controller reset or a new serial output bit from the same cycle is already visible. A shifted instruction bit is expected back on the output exactly four shift cycles after it went in. A bypassed bit is expected one shift cycle later. A boundary or identification bit is expected in the same cycle. All 16 instruction codes are swept through capture, shift and update, and the decode is checked against the table in R6.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;

    localparam int IR_W = 4;

    typedef logic [IR_W-1:0] ir_code_t;

    localparam ir_code_t OP_EXTEST = 4'b0000;
    localparam ir_code_t OP_SAMPLE = 4'b0001;
    localparam ir_code_t OP_IDENT  = 4'b0010;
    localparam ir_code_t OP_BYPASS = {IR_W{1'b1}};

    localparam ir_code_t CAPTURE_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    typedef enum logic [1:0] {
        SEL_BYPASS   = 2'b00,
        SEL_BOUNDARY = 2'b01,
        SEL_IDENT    = 2'b10
    } dr_sel_e;

    typedef struct packed {
        logic    mode;
        dr_sel_e sel;
    } ir_decode_t;

    function automatic ir_code_t reset_code(input bit has_id);
        return has_id ? OP_IDENT : OP_BYPASS;
    endfunction

    function automatic ir_decode_t decode_op(input ir_code_t op, input bit has_id);
        ir_decode_t d;
        d.mode = 1'b0;
        d.sel  = SEL_BYPASS;
        if (op == OP_EXTEST) begin
            d.mode = 1'b1;
            d.sel  = SEL_BOUNDARY;
        end else if (op == OP_SAMPLE) begin
            d.sel  = SEL_BOUNDARY;
        end else if (op == OP_IDENT && has_id) begin
            d.sel  = SEL_IDENT;
        end
        return d;
    endfunction

endpackage

// File: rtl/scan_ir_layers.sv
module scan_ir_layers
    import scan_ir_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tdi_i,
    input  logic     tlr_i,
    input  logic     capture_i,
    input  logic     shift_i,
    input  logic     update_i,
    output ir_code_t scan_o,
    output ir_code_t held_o
);

    ir_code_t scan_q;
    ir_code_t held_q;

    // scan layer: rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= CAPTURE_PAT;
        end else if (capture_i) begin
            scan_q <= CAPTURE_PAT;
        end else if (shift_i) begin
            scan_q <= {tdi_i, scan_q[IR_W-1:1]};
        end
    end

    // held layer: falling edge
    always_ff @(negedge clk) begin
        if (rst || tlr_i) begin
            held_q <= reset_code(HAS_ID);
        end else if (update_i) begin
            held_q <= scan_q;
        end
    end

    assign scan_o = scan_q;
    assign held_o = held_q;

    // R2
    a_r2_capture_pattern: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> scan_q == CAPTURE_PAT);

    // R3
    a_r3_shift_in_msb: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> scan_q[IR_W-1] == $past(tdi_i));

    // R4
    a_r4_held_stable: assert property (@(negedge clk) disable iff (rst)
        (!update_i && !tlr_i) |=> $stable(held_q));

    // R9
    a_r9_tlr_reload: assert property (@(negedge clk) disable iff (rst)
        tlr_i |=> held_q == reset_code(HAS_ID));

endmodule

// File: rtl/scan_ir_decode.sv
module scan_ir_decode
    import scan_ir_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  ir_code_t   op_i,
    output ir_decode_t dec_o
);

    always_comb begin
        dec_o = decode_op(op_i, HAS_ID);
    end

    // R6
    always_comb begin
        a_r6_mode_needs_boundary: assert (!dec_o.mode || dec_o.sel == SEL_BOUNDARY);
    end

endmodule

// File: rtl/scan_bypass_stage.sv
module scan_bypass_stage (
    input  logic clk,
    input  logic rst,
    input  logic tdi_i,
    input  logic capture_i,
    input  logic shift_i,
    output logic so_o
);

    logic byp_q;

    always_ff @(posedge clk) begin
        if (rst || capture_i) begin
            byp_q <= 1'b0;
        end else if (shift_i) begin
            byp_q <= tdi_i;
        end
    end

    assign so_o = byp_q;

    // R7
    a_r7_bypass_delay: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> byp_q == $past(tdi_i));

    // R7
    a_r7_bypass_capture: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> !byp_q);

endmodule

// File: rtl/scan_ir_unit.sv
module scan_ir_unit
    import scan_ir_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tdi_i,
    input  logic       tlr_i,
    input  logic       ir_capture_i,
    input  logic       ir_shift_i,
    input  logic       ir_update_i,
    input  logic       dr_capture_i,
    input  logic       dr_shift_i,
    input  logic       bsr_so_i,
    input  logic       idr_so_i,
    output logic       mode_o,
    output logic [1:0] dr_sel_o,
    output logic       tdo_o
);

    ir_code_t   scan_w;
    ir_code_t   held_w;
    ir_decode_t dec_w;
    logic       byp_so_w;
    logic       dr_so_w;
    logic       tdo_q;

    scan_ir_layers #(.HAS_ID(HAS_ID)) u_layers (
        .clk       (clk),
        .rst       (rst),
        .tdi_i     (tdi_i),
        .tlr_i     (tlr_i),
        .capture_i (ir_capture_i),
        .shift_i   (ir_shift_i),
        .update_i  (ir_update_i),
        .scan_o    (scan_w),
        .held_o    (held_w)
    );

    scan_ir_decode #(.HAS_ID(HAS_ID)) u_decode (
        .op_i  (held_w),
        .dec_o (dec_w)
    );

    scan_bypass_stage u_bypass (
        .clk       (clk),
        .rst       (rst),
        .tdi_i     (tdi_i),
        .capture_i (dr_capture_i),
        .shift_i   (dr_shift_i),
        .so_o      (byp_so_w)
    );

    generate
        if (HAS_ID) begin : g_with_id
            always_comb begin
                unique case (dec_w.sel)
                    SEL_BOUNDARY: dr_so_w = bsr_so_i;
                    SEL_IDENT:    dr_so_w = idr_so_i;
                    default:      dr_so_w = byp_so_w;
                endcase
            end
        end else begin : g_no_id
            assign dr_so_w = (dec_w.sel == SEL_BOUNDARY) ? bsr_so_i : byp_so_w;
        end
    endgenerate

    // serial output registered on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            tdo_q <= 1'b0;
        end else if (ir_shift_i) begin
            tdo_q <= scan_w[0];
        end else if (dr_shift_i) begin
            tdo_q <= dr_so_w;
        end else begin
            tdo_q <= 1'b0;
        end
    end

    assign mode_o   = dec_w.mode;
    assign dr_sel_o = dec_w.sel;
    assign tdo_o    = tdo_q;

    // R3
    a_r3_tdo_ir_lsb: assert property (@(negedge clk) disable iff (rst)
        ir_shift_i |=> tdo_q == $past(scan_w[0]));

    // R8
    a_r8_tdo_idle_low: assert property (@(negedge clk) disable iff (rst)
        (!ir_shift_i && !dr_shift_i) |=> !tdo_q);

endmodule

// File: tb/test_scan_ir_unit.sv
module test_scan_ir_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tdi = 1'b0, tlr = 1'b0;
    logic       icap = 1'b0, ishf = 1'b0, iupd = 1'b0;
    logic       dcap = 1'b0, dshf = 1'b0;
    logic       bso = 1'b0, iso = 1'b0;
    logic       mode;
    logic [1:0] sel;
    logic       tdo;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scan_ir_unit i_scan_ir_unit (
        .clk(clk), .rst(rst), .tdi_i(tdi), .tlr_i(tlr),
        .ir_capture_i(icap), .ir_shift_i(ishf), .ir_update_i(iupd),
        .dr_capture_i(dcap), .dr_shift_i(dshf),
        .bsr_so_i(bso), .idr_so_i(iso),
        .mode_o(mode), .dr_sel_o(sel), .tdo_o(tdo)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive after rising edge, return 2 ns after falling edge
    task automatic cyc(input logic c_ic, input logic c_is, input logic c_iu,
                       input logic c_dc, input logic c_ds, input logic c_tdi,
                       input logic c_bso, input logic c_iso, input logic c_tlr);
        @(posedge clk);
        #1;
        icap = c_ic; ishf = c_is; iupd = c_iu; dcap = c_dc; dshf = c_ds;
        tdi = c_tdi; bso = c_bso; iso = c_iso; tlr = c_tlr;
        @(negedge clk);
        #2;
    endtask

    function automatic int exp_sel(input logic [3:0] c);
        if (c == 4'b0000 || c == 4'b0001) return 1;
        if (c == 4'b0010) return 2;
        return 0;
    endfunction

    task automatic load_code(input logic [3:0] c, input bit chk);
        int sel_before;
        sel_before = sel;
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        if (chk) check("R4 capture keeps select", sel, sel_before);
        for (int k = 0; k < 8; k++) begin
            cyc(0, 1, 0, 0, 0, c[k%4], 0, 0, 0);
            if (chk) begin
                if (k < 4) check("R2 capture pattern out", tdo, (k == 0) ? 1 : 0);
                else       check("R3 shifted bit returns", tdo, c[k-4]);
                check("R4 select held during shift", sel, sel_before);
            end
        end
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
        if (chk) begin
            check("R5 R6 select after update", sel, exp_sel(c));
            check("R6 mode after update", mode, (c == 4'b0000) ? 1 : 0);
            check("R8 idle output low", tdo, 0);
        end
    endtask

    initial begin
        logic prev;
        logic b;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #2;
        check("R1 reset select", sel, 2);
        check("R1 reset mode", mode, 0);
        check("R1 reset output", tdo, 0);

        // R6 sweep of all codes
        for (int c = 0; c < 16; c++) load_code(4'(c), 1'b1);

        // R7 bypass path
        load_code(4'b1111, 1'b0);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
        prev = 1'b0;
        for (int k = 0; k < 16; k++) begin
            b = ((k * 5 + 3) % 7) > 2;
            cyc(0, 0, 0, 0, 1, b, ~b, b, 0);
            check("R7 bypass one-cycle delay", tdo, prev);
            prev = b;
        end

        // R8 boundary path
        load_code(4'b0001, 1'b0);
        for (int k = 0; k < 8; k++) begin
            b = (k % 3) == 1;
            cyc(0, 0, 0, 0, 1, ~b, b, ~b, 0);
            check("R8 boundary serial out", tdo, b);
        end

        // R8 identification path
        load_code(4'b0010, 1'b0);
        for (int k = 0; k < 8; k++) begin
            b = (k % 2) == 0;
            cyc(0, 0, 0, 0, 1, ~b, ~b, b, 0);
            check("R8 ident serial out", tdo, b);
        end
        cyc(0, 0, 0, 0, 0, 1, 1, 1, 0);
        check("R8 idle output low", tdo, 0);

        // R9 controller reset reloads
        load_code(4'b0000, 1'b0);
        check("R9 pre mode", mode, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 reload select", sel, 2);
        check("R9 reload mode", mode, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule